// File: doc/BRIEF.md
# Ordered Clock Ratio Sequencer

This block derives three clock-enable strobes from one fast source clock: a core strobe, a peripheral-bus strobe that runs at half the core rate or slower, and a memory-interface strobe. A single-cycle request carries a new pair of core and peripheral divide ratios. The block decides which divider to reprogram first so that the peripheral rate never rises above half the core rate, even for one period, and it applies each new ratio only when that divider finishes its current period.

A second request type announces a change of the multiplier or the input setting upstream. The block then raises a bypass flag and holds it for a programmable number of reference cycles while the loop relocks. A select input chooses whether the memory strobe comes from an external strobe input or from a fixed internal divider. A constant flag reports whether the frequency parameters put the loop output or the memory clock outside their allowed bands.

Top module: `clk_ratio_seq`

## Requirements
- R1: After reset the core ratio is 1 and the peripheral ratio is 2. Both counters start at 0, so core_tick is high in the first cycle and per_tick is low. busy, bypass, done, err and overrun are all 0.
- R2: With core ratio N, core_tick is high for one cycle every N cycles. per_tick behaves the same way with its own ratio. clkout_tick always equals per_tick.
- R3: A ratio request is valid only when all of these hold: both enable bits are 1, the core ratio is nonzero, and the peripheral ratio is exactly twice the core ratio. For an invalid request made while idle, err pulses for one cycle on the next cycle and both ratios stay unchanged.
- R4: When the new core ratio is greater than or equal to the current one, the peripheral ratio is replaced first. The core ratio is replaced second.
- R5: When the new core ratio is smaller than the current one, the core ratio is replaced first. The peripheral ratio is replaced second.
- R6: A ratio is replaced only in the cycle in which that divider's strobe fires. No strobe interval is ever cut short.
- R7: Every completed peripheral strobe interval is at least twice the most recently completed core strobe interval.
- R8: busy is high from the cycle after a request is accepted until its sequence ends. done pulses for one cycle as busy falls.
- R9: An accepted loop-change request (pll_chg while idle) raises bypass for lock_cycles+1 cycles. bypass then falls together with a done pulse.
- R10: Any request made while busy is ignored and sets overrun. If pll_chg and req_valid arrive in the same idle cycle, pll_chg is taken and the ratio request counts as an overrun. Only reset clears overrun.
- R11: With mem_sel=1, mem_tick follows ext_mem_tick. With mem_sel=0, mem_tick fires one cycle in every MEM_DIV cycles from a free-running counter.
- R12: range_bad is 1 when SRC_MHZ*PLL_MULT lies outside 100..600, or when that product divided by MEM_DIV lies outside 66..100. Otherwise range_bad is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast source clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | one-cycle ratio request |
| req_core_div | input | DW | requested core ratio |
| req_core_on | input | 1 | core divider enable, must be 1 |
| req_per_div | input | DW+1 | requested peripheral ratio |
| req_per_on | input | 1 | peripheral divider enable, must be 1 |
| pll_chg | input | 1 | multiplier or input change request |
| lock_cycles | input | LW | relock wait length |
| mem_sel | input | 1 | memory strobe source: 1 external, 0 internal |
| ext_mem_tick | input | 1 | external memory strobe |
| core_tick | output | 1 | core clock enable |
| per_tick | output | 1 | peripheral clock enable |
| clkout_tick | output | 1 | copy of per_tick for the clock-output pin |
| mem_tick | output | 1 | memory-interface clock enable |
| busy | output | 1 | sequence or relock in progress |
| bypass | output | 1 | loop bypassed during relock |
| done | output | 1 | one-cycle end-of-sequence pulse |
| err | output | 1 | one-cycle invalid-request pulse |
| overrun | output | 1 | sticky flag for a request ignored while busy |
| range_bad | output | 1 | frequency parameters out of band |

## Verification
The bench builds the main instance with DW=4, so the largest legal pair, 15 and 30, is reachable. That lets it check the widest slow-down and speed-up transitions against a strobe-interval monitor. LW=8 keeps the relock windows short, including the zero-length wait. A second instance, with a multiplier of 20 and a memory divider of 4, places the memory clock at 125 MHz so that the out-of-band flag is exercised. The default main instance, at 400 and 80 MHz, shows the flag clear.

// File: rtl/clk_ratio_seq.sv
module clk_ratio_seq #(
  parameter int DW       = 8,
  parameter int LW       = 16,
  parameter int SRC_MHZ  = 25,
  parameter int PLL_MULT = 16,
  parameter int MEM_DIV  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [DW-1:0] req_core_div,
  input  logic          req_core_on,
  input  logic [DW:0]   req_per_div,
  input  logic          req_per_on,
  input  logic          pll_chg,
  input  logic [LW-1:0] lock_cycles,
  input  logic          mem_sel,
  input  logic          ext_mem_tick,
  output logic          core_tick,
  output logic          per_tick,
  output logic          clkout_tick,
  output logic          mem_tick,
  output logic          busy,
  output logic          bypass,
  output logic          done,
  output logic          err,
  output logic          overrun,
  output logic          range_bad
);
  localparam int PW      = DW + 1;
  localparam int MW      = $clog2(MEM_DIV + 1);
  localparam int PLL_MHZ = SRC_MHZ * PLL_MULT;
  localparam int MEM_MHZ = PLL_MHZ / MEM_DIV;

  typedef enum logic [2:0] {IDLE, P_FIRST, C_LAST, C_FIRST, P_LAST, LOCK} st_t;
  st_t st;

  logic [DW-1:0] cdiv, tc, ccnt;
  logic [PW-1:0] pdiv, tp, pcnt;
  logic [LW-1:0] lcnt;
  logic [MW-1:0] mcnt;
  logic          mem_int;

  wire req_ok = req_core_on && req_per_on && (req_core_div != '0) &&
                (req_per_div == {req_core_div, 1'b0});

  assign core_tick   = (ccnt == cdiv - 1'b1);
  assign per_tick    = (pcnt == pdiv - 1'b1);
  assign clkout_tick = per_tick;
  assign mem_int     = (mcnt == MW'(MEM_DIV - 1));
  assign mem_tick    = mem_sel ? ext_mem_tick : mem_int;
  assign busy        = (st != IDLE);
  assign bypass      = (st == LOCK);
  assign range_bad   = (PLL_MHZ < 100) || (PLL_MHZ > 600) ||
                       (MEM_MHZ < 66) || (MEM_MHZ > 100);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt <= '0;
      pcnt <= '0;
      mcnt <= '0;
    end else begin
      ccnt <= core_tick ? '0 : ccnt + 1'b1;
      pcnt <= per_tick ? '0 : pcnt + 1'b1;
      mcnt <= mem_int ? '0 : mcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cdiv    <= DW'(1);
      pdiv    <= PW'(2);
      tc      <= '0;
      tp      <= '0;
      lcnt    <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      overrun <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (st != IDLE && (req_valid || pll_chg)) overrun <= 1'b1;
      case (st)
        IDLE: begin
          if (pll_chg) begin
            st   <= LOCK;
            lcnt <= lock_cycles;
            if (req_valid) overrun <= 1'b1;
          end else if (req_valid) begin
            if (!req_ok) err <= 1'b1;
            else begin
              tc <= req_core_div;
              tp <= req_per_div;
              st <= (req_core_div >= cdiv) ? P_FIRST : C_FIRST;
            end
          end
        end
        P_FIRST: if (per_tick)  begin pdiv <= tp; st <= C_LAST; end
        C_LAST:  if (core_tick) begin cdiv <= tc; st <= IDLE; done <= 1'b1; end
        C_FIRST: if (core_tick) begin cdiv <= tc; st <= P_LAST; end
        P_LAST:  if (per_tick)  begin pdiv <= tp; st <= IDLE; done <= 1'b1; end
        LOCK: begin
          if (lcnt == '0) begin st <= IDLE; done <= 1'b1; end
          else lcnt <= lcnt - 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r7_ratio_floor: assert property (@(posedge clk) disable iff (!rst_n)
    pdiv >= {cdiv, 1'b0});
  a_r6_core_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cdiv) |-> $past(core_tick));
  a_r6_per_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pdiv) |-> $past(per_tick));
  a_r3_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(cdiv) && $stable(pdiv) && !busy));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_bypass_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass) |-> $past(pll_chg));
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: tb/clk_ratio_seq_test.sv
`timescale 1ns/1ps
module clk_ratio_seq_test;
  localparam int DW = 4, LW = 8, MD = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_core_on = 0, req_per_on = 0, pll_chg = 0;
  logic [DW-1:0] req_core_div = '0;
  logic [DW:0]   req_per_div = '0;
  logic [LW-1:0] lock_cycles = '0;
  logic mem_sel = 0, ext_mem_tick = 0;
  logic core_tick, per_tick, clkout_tick, mem_tick, busy, bypass, done, err, overrun, range_bad;
  logic b_core, b_per, b_clko, b_mem, b_busy, b_byp, b_done, b_err, b_ovr, b_range;

  int checks = 0, fails = 0;
  string cur_tag = "R2";
  bit finished = 0;

  always #2.5 clk = ~clk;

  clk_ratio_seq #(.DW(DW), .LW(LW), .SRC_MHZ(25), .PLL_MULT(16), .MEM_DIV(MD)) uut (
    .clk, .rst_n, .req_valid, .req_core_div, .req_core_on, .req_per_div, .req_per_on,
    .pll_chg, .lock_cycles, .mem_sel, .ext_mem_tick, .core_tick, .per_tick, .clkout_tick,
    .mem_tick, .busy, .bypass, .done, .err, .overrun, .range_bad);

  clk_ratio_seq #(.DW(DW), .LW(LW), .SRC_MHZ(25), .PLL_MULT(20), .MEM_DIV(4)) uut_bad (
    .clk, .rst_n, .req_valid(1'b0), .req_core_div('0), .req_core_on(1'b0), .req_per_div('0),
    .req_per_on(1'b0), .pll_chg(1'b0), .lock_cycles('0), .mem_sel(1'b0), .ext_mem_tick(1'b0),
    .core_tick(b_core), .per_tick(b_per), .clkout_tick(b_clko), .mem_tick(b_mem), .busy(b_busy),
    .bypass(b_byp), .done(b_done), .err(b_err), .overrun(b_ovr), .range_bad(b_range));

  task automatic chk(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // behavioural reference model
  int m_c, m_p, cage, page, mage, lock_left, ext_n;
  bit lock_on, m_done, m_err, m_ovr;
  int qw[$], qv[$];

  always @(posedge clk) begin
    bit ct, pt, was_busy;
    int nc, np;
    if (!rst_n) begin
      m_c = 1; m_p = 2; cage = 0; page = 0; mage = 0;
      lock_on = 0; lock_left = 0; m_done = 0; m_err = 0; m_ovr = 0;
      qw.delete(); qv.delete();
    end else begin
      ct = (cage == m_c - 1);
      pt = (page == m_p - 1);
      was_busy = lock_on || (qw.size() > 0);
      nc = m_c; np = m_p; m_done = 0; m_err = 0;
      if (was_busy) begin
        if (req_valid || pll_chg) m_ovr = 1;
        if (lock_on) begin
          if (lock_left == 0) begin lock_on = 0; m_done = 1; end
          else lock_left--;
        end else if ((qw[0] == 0 && ct) || (qw[0] == 1 && pt)) begin
          if (qw[0] == 0) nc = qv[0]; else np = qv[0];
          void'(qw.pop_front()); void'(qv.pop_front());
          if (qw.size() == 0) m_done = 1;
        end
      end else if (pll_chg) begin
        lock_on = 1; lock_left = int'(lock_cycles);
        if (req_valid) m_ovr = 1;
      end else if (req_valid) begin
        if (req_core_on && req_per_on && req_core_div != 0 &&
            int'(req_per_div) == 2 * int'(req_core_div)) begin
          if (int'(req_core_div) >= m_c) begin
            qw.push_back(1); qv.push_back(int'(req_per_div));
            qw.push_back(0); qv.push_back(int'(req_core_div));
          end else begin
            qw.push_back(0); qv.push_back(int'(req_core_div));
            qw.push_back(1); qv.push_back(int'(req_per_div));
          end
        end else m_err = 1;
      end
      cage = ct ? 0 : cage + 1;
      page = pt ? 0 : page + 1;
      mage = (mage == MD - 1) ? 0 : mage + 1;
      m_c = nc; m_p = np;
    end
  end

  always @(posedge clk) begin
    #1;
    ext_n++;
    ext_mem_tick = (ext_n % 3 == 0);
  end

  // per-cycle comparison and interval monitor
  int csince = 0, psince = 0, last_ci = 0;
  bit c_go = 0, p_go = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_tag, "core_tick", core_tick, cage == m_c - 1);
      chk(cur_tag, "per_tick", per_tick, page == m_p - 1);
      chk("R2", "clkout_tick", clkout_tick, per_tick);
      chk("R11", "mem_tick", mem_tick, mem_sel ? ext_mem_tick : (mage == MD - 1));
      chk("R8", "busy", busy, lock_on || qw.size() > 0);
      chk("R8", "done", done, m_done);
      chk("R9", "bypass", bypass, lock_on);
      chk("R3", "err", err, m_err);
      chk("R10", "overrun", overrun, m_ovr);
      csince++; psince++;
      if (core_tick) begin
        if (c_go) last_ci = csince;
        csince = 0; c_go = 1;
      end
      if (per_tick) begin
        if (p_go && last_ci > 0 && psince < 2 * last_ci)
          chk("R7", "per_interval", psince, 2 * last_ci);
        psince = 0; p_go = 1;
      end
    end
  end

  task automatic req(int c, bit con, int p, bit pon);
    @(posedge clk); #1;
    req_valid = 1; req_core_div = DW'(c); req_core_on = con;
    req_per_div = (DW+1)'(p); req_per_on = pon;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic lock_req(int n, bit with_req);
    @(posedge clk); #1;
    pll_chg = 1; lock_cycles = LW'(n); req_valid = with_req;
    req_core_div = 4'd2; req_core_on = 1; req_per_div = 5'd4; req_per_on = 1;
    @(posedge clk); #1;
    pll_chg = 0; req_valid = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (40) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", "reset core_tick", core_tick, 1);
    chk("R1", "reset per_tick", per_tick, 0);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset bypass", bypass, 0);
    chk("R1", "reset overrun", overrun, 0);
    chk("R12", "range_bad default", range_bad, 0);
    chk("R12", "range_bad 125MHz mem", b_range, 1);
    repeat (10) @(posedge clk);

    cur_tag = "R4"; req(5, 1, 10, 1); wait_idle();
    cur_tag = "R5"; req(3, 1, 6, 1); wait_idle();
    req(1, 1, 2, 1); wait_idle();

    cur_tag = "R3";
    req(2, 0, 4, 1); req(2, 1, 4, 0); req(2, 1, 5, 1); req(0, 1, 0, 1);
    repeat (10) @(posedge clk);

    cur_tag = "R6";
    repeat (1) @(posedge clk);
    req(15, 1, 30, 1);
    req(2, 1, 4, 1);
    wait_idle();
    req(2, 1, 4, 1); wait_idle();
    req(15, 1, 30, 1); wait_idle();
    cur_tag = "R5"; req(1, 1, 2, 1); wait_idle();

    cur_tag = "R2";
    lock_req(4, 0);
    req(3, 1, 6, 1);
    wait_idle();
    lock_req(0, 0); wait_idle();
    lock_req(6, 1); wait_idle();

    @(posedge clk); #1 mem_sel = 1;
    repeat (20) @(posedge clk);
    #1 mem_sel = 0;
    repeat (20) @(posedge clk);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=hung expected=idle");
      summary();
      $finish;
    end
  end
endmodule